// File: doc/BRIEF.md
# Stack Push/Pop Execution Unit

This block carries out single-register push and pop operations for a processor whose register file has 16 entries of 32 bits. It accepts one 16-bit instruction word at a time over a valid/ready handshake, works out whether the word is a stack operation, and then runs the operation to the end. Register 14 is always the stack pointer, and the stack grows toward lower addresses.

A push lowers the stack pointer by 4 and stores the named register at the new address. A pop reads the word at the current stack pointer into the named register and then raises the stack pointer by 4. The memory transfer uses a 32-bit word port. The request is held until the memory answers with ready. The register file is read through one combinational read port plus a dedicated stack-pointer read, and it is written through one write port.

Back-pressure on the instruction stream is simple. `instr_ready` is high only while the unit is idle. A word is taken on a clock edge where both `instr_valid` and `instr_ready` are high. `instr_ready` then stays low until the operation has finished, so the sender must hold its next word. The `done` and `illegal` outputs are plain single-cycle pulses and have no handshake.

Top module: `stack_unit`

## Requirements
- R1: An instruction is a stack operation when bits [15:12] equal 15. Bits [11:8] name the register. A low byte [7:0] of 1 selects pop and a low byte of 2 selects push.
- R2: A push writes R14-4 back into R14 and stores the named register at address R14-4. The stored value is the one read before any update, so pushing R14 stores the old stack pointer.
- R3: A pop loads the word at address R14 into the named register and sets R14 to R14+4.
- R4: A pop into R14 leaves R14 equal to the loaded word. The load takes priority over the increment.
- R5: A word with a low byte other than 1 or 2, or with bits [15:12] not equal to 15, pulses `illegal` for one cycle in its acceptance cycle. It issues no memory request and makes no register write.
- R6: `mem_req` is held high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until a cycle in which `mem_ready` is high. The request then drops, so each operation uses exactly latency+1 request cycles.
- R7: `done` pulses for one cycle together with the final register write. With a memory latency of L wait cycles, this is L+2 cycles after acceptance for a push and L+3 cycles for a pop.
- R8: `instr_ready` is high only when idle. A word held valid throughout an operation is executed once.
- R9: After reset the unit is idle: `instr_ready` is 1, and `mem_req`, `rf_wr_en`, `done` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle, word may be taken |
| instr | input | 16 | Instruction word |
| rf_rd_addr | output | 4 | Register-file read index (named register) |
| rf_rd_data | input | 32 | Contents of the register at rf_rd_addr |
| rf_sp_data | input | 32 | Contents of R14 |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_addr | output | 4 | Register write index |
| rf_wr_data | output | 32 | Register write value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory completes request this cycle |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| done | output | 1 | Operation finished pulse |
| illegal | output | 1 | Rejected instruction pulse |

## Verification
If the captured direction flag is wrong, the error shows up as a load in place of a store (or the reverse) on the first request cycle, one cycle after acceptance. The stack pointer also moves the wrong way. If the captured address is wrong, the stored or loaded word appears at the wrong memory location, and a later pop that reads it back exposes the error. A stuck state register shows within a few cycles as a missing `done`, a `done` at the wrong cycle, or `instr_ready` failing to return. A chain of dependent pushes and pops, including pops into R14, carries an early error forward so that the register or memory comparison after each instruction catches it.

// File: rtl/stack_pkg.sv
package stack_pkg;
  localparam int unsigned RF_AW    = 4;
  localparam logic [3:0]  OPC_STACK = 4'hF;
  localparam logic [7:0]  SEL_POP   = 8'd1;
  localparam logic [7:0]  SEL_PUSH  = 8'd2;
  localparam logic [RF_AW-1:0] SP_IDX = RF_AW'(14);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEM,
    ST_WSP,
    ST_WREG
  } st_e;

  typedef struct packed {
    logic             legal;
    logic             is_push;
    logic [RF_AW-1:0] rn;
  } dec_t;
endpackage

// File: rtl/stack_decode.sv
module stack_decode
  import stack_pkg::*;
(
  input  logic [15:0] instr,
  output dec_t        dec
);
  logic opc_hit;
  logic is_pop;
  logic is_push;

  always_comb begin
    opc_hit = (instr[15:12] == OPC_STACK);
    is_pop  = (instr[7:0] == SEL_POP);
    is_push = (instr[7:0] == SEL_PUSH);
    dec.legal   = opc_hit && (is_pop || is_push);
    dec.is_push = is_push;
    dec.rn      = instr[11:8];
  end
endmodule

// File: rtl/stack_agen.sv
module stack_agen #(
  parameter int unsigned DW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic [DW-1:0] sp,
  input  logic          push_now,
  input  logic [DW-1:0] addr_q,
  input  logic          push_q,
  output logic [DW-1:0] base,
  output logic [DW-1:0] sp_upd
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  always_comb begin
    base   = push_now ? (sp - STEP_V) : sp;
    sp_upd = push_q ? addr_q : (addr_q + STEP_V);
  end
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  output logic             instr_ready,
  input  dec_t             dec,
  input  logic [DW-1:0]    rd_data,
  input  logic [DW-1:0]    base_in,
  input  logic [DW-1:0]    sp_upd,
  output logic [DW-1:0]    addr_q,
  output logic             push_q,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_rdata,
  output logic             rf_wr_en,
  output logic [RF_AW-1:0] rf_wr_addr,
  output logic [DW-1:0]    rf_wr_data,
  output logic             done,
  output logic             illegal
);
  st_e              state;
  logic [RF_AW-1:0] rn_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    rdata_q;
  logic             accept;

  always_comb begin
    instr_ready = (state == ST_IDLE);
    accept      = instr_valid && instr_ready;
    illegal     = accept && !dec.legal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      push_q  <= 1'b0;
      rn_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept && dec.legal) begin
          push_q  <= dec.is_push;
          rn_q    <= dec.rn;
          addr_q  <= base_in;
          wdata_q <= rd_data;
          state   <= ST_MEM;
        end
        ST_MEM: if (mem_ready) begin
          if (!push_q) rdata_q <= mem_rdata;
          state <= ST_WSP;
        end
        ST_WSP:  state <= push_q ? ST_IDLE : ST_WREG;
        ST_WREG: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req    = (state == ST_MEM);
    mem_we     = push_q;
    mem_addr   = addr_q;
    mem_wdata  = wdata_q;
    rf_wr_en   = (state == ST_WSP) || (state == ST_WREG);
    rf_wr_addr = (state == ST_WSP) ? SP_IDX : rn_q;
    rf_wr_data = (state == ST_WSP) ? sp_upd : rdata_q;
    done       = ((state == ST_WSP) && push_q) || (state == ST_WREG);
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> !mem_req);

  // R5
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_req && !rf_wr_en && !done));

  // R5
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (instr_ready && !mem_req));

  // R7
  done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rf_wr_en);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rf_wr_en) |-> !instr_ready);

  // R4
  pop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && !done) |=> (rf_wr_en && done));
endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
  parameter int unsigned DW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [15:0]   instr,
  output logic [3:0]    rf_rd_addr,
  input  logic [DW-1:0] rf_rd_data,
  input  logic [DW-1:0] rf_sp_data,
  output logic          rf_wr_en,
  output logic [3:0]    rf_wr_addr,
  output logic [DW-1:0] rf_wr_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          illegal
);
  import stack_pkg::*;

  dec_t          dec;
  logic [DW-1:0] base;
  logic [DW-1:0] sp_upd;
  logic [DW-1:0] addr_q;
  logic          push_q;

  assign rf_rd_addr = dec.rn;

  stack_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  stack_agen #(.DW(DW), .STEP(STEP)) u_agen (
    .sp       (rf_sp_data),
    .push_now (dec.is_push),
    .addr_q   (addr_q),
    .push_q   (push_q),
    .base     (base),
    .sp_upd   (sp_upd)
  );

  stack_ctrl #(.DW(DW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .dec         (dec),
    .rd_data     (rf_rd_data),
    .base_in     (base),
    .sp_upd      (sp_upd),
    .addr_q      (addr_q),
    .push_q      (push_q),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .mem_rdata   (mem_rdata),
    .rf_wr_en    (rf_wr_en),
    .rf_wr_addr  (rf_wr_addr),
    .rf_wr_data  (rf_wr_data),
    .done        (done),
    .illegal     (illegal)
  );
endmodule

// File: tb/test_stack_unit.sv
`timescale 1ns/1ps
module test_stack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr = 16'h0;
  logic [3:0]  rf_rd_addr;
  logic [31:0] rf_rd_data, rf_sp_data;
  logic        rf_wr_en;
  logic [3:0]  rf_wr_addr;
  logic [31:0] rf_wr_data;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, illegal;

  always #2.5 clk = ~clk;

  stack_unit i_stack_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data), .rf_sp_data(rf_sp_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done), .illegal(illegal)
  );

  // environment: register file and word memory
  logic [31:0] rf [16];
  logic [31:0] mem [64];
  logic [3:0]  lat_cfg = 4'd0;
  logic [3:0]  wait_cnt;
  int          req_cycles;

  assign rf_rd_data = rf[rf_rd_addr];
  assign rf_sp_data = rf[14];
  assign mem_ready  = mem_req && (wait_cnt == lat_cfg);
  assign mem_rdata  = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rf[i] <= 32'hA000_0000 + 32'(i * 17);
      rf[14] <= 32'h0000_0080;
      for (int i = 0; i < 64; i++) mem[i] <= 32'h5000_0000 + 32'(i);
      wait_cnt <= 4'd0;
    end else begin
      if (rf_wr_en) rf[rf_wr_addr] <= rf_wr_data;
      if (mem_req && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      if (mem_req && !mem_ready) wait_cnt <= wait_cnt + 4'd1;
      else wait_cnt <= 4'd0;
      if (mem_req) req_cycles <= req_cycles + 1;
    end
  end

  // reference model
  logic [31:0] exp_rf [16];
  logic [31:0] exp_mem [64];
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] w);
    logic [3:0]  rn;
    logic [31:0] sp, v;
    rn = w[11:8];
    sp = exp_rf[14];
    if (w[15:12] != 4'hF) return;
    if (w[7:0] == 8'd2) begin
      exp_mem[(sp - 32'd4) >> 2 & 32'h3F] = exp_rf[rn];
      exp_rf[14] = sp - 32'd4;
    end else if (w[7:0] == 8'd1) begin
      v = exp_mem[sp >> 2 & 32'h3F];
      exp_rf[14] = sp + 32'd4;
      exp_rf[rn] = v;
    end
  endtask

  task automatic compare_state(input string req);
    int bad_r, bad_m;
    bad_r = -1; bad_m = -1;
    for (int i = 0; i < 16; i++) if (rf[i] !== exp_rf[i] && bad_r < 0) bad_r = i;
    for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i] && bad_m < 0) bad_m = i;
    check(bad_r < 0, req, "register file", bad_r < 0 ? 32'h0 : rf[bad_r],
          bad_r < 0 ? 32'h0 : exp_rf[bad_r]);
    check(bad_m < 0, req, "memory", bad_m < 0 ? 32'h0 : mem[bad_m],
          bad_m < 0 ? 32'h0 : exp_mem[bad_m]);
  endtask

  task automatic run(input logic [15:0] w, input logic [3:0] lat, input bit hold);
    bit legal;
    int n;
    legal = (w[15:12] == 4'hF) && (w[7:0] == 8'd1 || w[7:0] == 8'd2);
    lat_cfg = lat;
    req_cycles = 0;
    model(w);
    @(negedge clk);
    instr = w;
    instr_valid = 1'b1;
    #1;
    check(instr_ready === 1'b1, "R8", "ready before accept", {31'd0, instr_ready}, 32'd1);
    check(illegal === !legal, "R5", "illegal pulse", {31'd0, illegal}, {31'd0, !legal});
    @(negedge clk);
    if (!hold) instr_valid = 1'b0;
    n = 1;
    if (legal) begin
      while (!done && n < 40) begin
        @(negedge clk);
        n++;
      end
      instr_valid = 1'b0;
      check(n == 32'(lat) + (w[7:0] == 8'd2 ? 2 : 3), "R7", "done cycle",
            32'(n), 32'(lat) + (w[7:0] == 8'd2 ? 32'd2 : 32'd3));
      @(negedge clk);
      check(instr_ready === 1'b1 && !done, "R8", "idle after done", {31'd0, instr_ready}, 32'd1);
      check(req_cycles == 32'(lat) + 1, "R6", "request cycles", 32'(req_cycles), 32'(lat) + 1);
    end else begin
      repeat (3) @(negedge clk);
      check(req_cycles == 0 && !rf_wr_en, "R5", "no activity", 32'(req_cycles), 32'd0);
    end
    compare_state(w[7:0] == 8'd1 && w[11:8] == 4'd14 ? "R4" :
                  w[7:0] == 8'd1 ? "R3" : w[7:0] == 8'd2 ? "R2" : "R5");
  endtask

  // {instr, latency}: push=low byte 2, pop=low byte 1, opcode 15 in [15:12] (R1)
  localparam logic [19:0] VEC [0:11] = '{
    {16'hF302, 4'd0},
    {16'hF502, 4'd2},
    {16'hF701, 4'd1},
    {16'hFE02, 4'd0},
    {16'hF201, 4'd3},
    {16'hF103, 4'd0},
    {16'hF100, 4'd0},
    {16'h3302, 4'd0},
    {16'hF902, 4'd1},
    {16'hFE01, 4'd0},
    {16'hF002, 4'd4},
    {16'hF101, 4'd0}
  };

  initial begin
    #200000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(instr_ready === 1'b1, "R9", "instr_ready in reset", {31'd0, instr_ready}, 32'd1);
    check(!mem_req && !rf_wr_en && !done && !illegal, "R9", "quiet outputs",
          {28'd0, mem_req, rf_wr_en, done, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) exp_rf[i] = rf[i];
    for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
    check(instr_ready === 1'b1, "R9", "idle after reset", {31'd0, instr_ready}, 32'd1);

    for (int k = 0; k < 12; k++) run(VEC[k][19:4], VEC[k][3:0], 1'b0);

    // R8: word held valid across the whole push executes only once
    run(16'hF402, 4'd2, 1'b1);
    // R4: pop into R14 right after pushing R14 restores the old pointer
    run(16'hFE02, 4'd1, 1'b0);
    run(16'hFE01, 4'd2, 1'b0);
    check(rf[14] === exp_rf[14], "R4", "sp after push/pop of R14", rf[14], exp_rf[14]);
    // R5: opcode 15 with low byte 0xFF, then a legal op still works
    run(16'hF6FF, 4'd0, 1'b0);
    run(16'hF601, 4'd0, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule